// File: doc/BRIEF.md
# Dual-Phase Framed Serial Receiver

This block takes a serial bit stream, a bit clock and a frame-sync line and turns them into parallel words. A frame holds one or two phases. Each phase has its own word length and its own count of words. The bit clock and the sync line are sampled in the system clock domain. A polarity bit picks which bit-clock edge samples data, and a second polarity bit picks the active level of the sync.

Each finished word goes from the shift register into a buffer register, then into the data register that the host reads. A ready flag marks unread data. A read strobe takes the data and clears the flag. If a word arrives while the previous one is still unread, the new word is dropped and an overrun flag is raised. A two-bit selector picks one of four event sources to drive a single-cycle interrupt pulse.

Configuration is held on static inputs and may change only between frames. The serial inputs are assumed to be synchronous to `clk`, and the bit clock runs at no more than a quarter of the `clk` rate.

Top module: `srx_top`

## Requirements
- R1: Exactly one data bit is taken per bit-clock period, on the rising edge of `ser_clk` when `clk_pol`=1 and on the falling edge when `clk_pol`=0.
- R2: The sync is active high when `fs_pol`=1 and active low when `fs_pol`=0. A frame starts at the sampling edge where the sync is active and was inactive at the previous sampling edge. The bit taken on that edge is the most significant bit of the first word. Bits arrive MSB first. Words are right-aligned in `rx_data` with the upper bits zero.
- R3: The word length code maps 0→8, 1→12, 2→16, 3→20, 4→24 and 5→32 bits. Codes 6 and 7 also give 32 bits.
- R4: A words-per-phase field holds the count minus one, so 0 gives one word and 127 gives 128 words.
- R5: With `dual_phase`=0 a frame is phase 1 only. With `dual_phase`=1, phase 2 uses `p2_len`/`p2_cnt` after phase 1 ends.
- R6: A word passes from the shift register to the buffer register and then into `rx_data`. `rdy` rises when `rx_data` receives a new word. A one-cycle `rd` strobe clears `rdy`.
- R7: If a buffered word meets `rdy`=1 with no `rd` in that cycle, the word is dropped, `rx_data` keeps the unread word and `ovr` sets. `rd` clears `ovr`.
- R8: After the last word of a frame, bits are ignored until the next frame start.
- R9: A frame start that arrives before the current frame completes is a sync error. The frame restarts from its first bit and the partial word is discarded.
- R10: With `irq_mode`=00, `irq` pulses for one cycle each time `rx_data` is loaded.
- R11: With `irq_mode`=01, `irq` pulses once after every 16th word of a frame, counted across both phases.
- R12: With `irq_mode`=10, `irq` pulses once per frame start.
- R13: With `irq_mode`=11, `irq` pulses once per sync error.
- R14: After reset `rdy`, `ovr` and `irq` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_fs | input | 1 | Frame sync |
| ser_dat | input | 1 | Serial data |
| clk_pol | input | 1 | 1: sample on rising edge, 0: on falling edge |
| fs_pol | input | 1 | 1: sync active high, 0: active low |
| dual_phase | input | 1 | 1: two phases per frame |
| p1_len | input | 3 | Phase 1 word length code |
| p1_cnt | input | 7 | Phase 1 words minus one |
| p2_len | input | 3 | Phase 2 word length code |
| p2_cnt | input | 7 | Phase 2 words minus one |
| irq_mode | input | 2 | Interrupt source select |
| rd | input | 1 | Read strobe for the data register |
| rx_data | output | 32 | Data register |
| rdy | output | 1 | Unread data present |
| ovr | output | 1 | Word lost to overrun |
| irq | output | 1 | Selected event pulse |

## Verification
The bench goes after the phase hand-over in a dual-phase frame. A design that ignored the second phase fields would deliver a wrong-length word or stop after phase 1. It checks every length code, including the unused ones. An off-by-one in the count field shows up as a missing or an extra word. A sync restart in the middle of a word is checked. A design that kept the partial bits would shift the next word, and one that did not restart would lose alignment. The bench also covers an overrun with no read, where a wrong design overwrites the unread word. Other cases are bits that follow a completed frame, a 17-word frame that must raise exactly one block event, and falling-edge, active-low operation.

// File: rtl/srx_pkg.sv
// Shared types and helpers for the framed serial receiver.
package srx_pkg;
    typedef enum logic [1:0] {
        IRQ_LOAD   = 2'b00,
        IRQ_BLOCK  = 2'b01,
        IRQ_FRAME  = 2'b10,
        IRQ_SYNERR = 2'b11
    } irq_sel_e;

    // Converts a 3-bit length code into a bit count; unused codes give 32.
    function automatic logic [5:0] code_to_len(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd8;
            3'd1:    return 6'd12;
            3'd2:    return 6'd16;
            3'd3:    return 6'd20;
            3'd4:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/srx_edge.sv
// Detects the chosen sampling edge of the bit clock and the start of a frame.
// Assumes ser_clk and ser_fs are synchronous to clk and change at most every
// other clk cycle.
module srx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_fs,
    input  logic clk_pol,
    input  logic fs_pol,
    output logic smp,
    output logic fs_start
);
    logic sck_q;
    logic fs_prev;
    logic fs_act;

    // Sampling strobe and sync activity decode.
    always_comb begin
        smp      = clk_pol ? (ser_clk & ~sck_q) : (~ser_clk & sck_q);
        fs_act   = fs_pol ? ser_fs : ~ser_fs;
        fs_start = smp & fs_act & ~fs_prev;
    end

    // Remembers the last bit-clock level and the sync level at the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            fs_prev <= 1'b0;
        end else begin
            sck_q <= ser_clk;
            if (smp) fs_prev <= fs_act;
        end
    end
endmodule

// File: rtl/srx_framer.sv
// Shift register and frame sequencer: counts bits, words and phases, and
// reports finished words, frame starts, sync errors and block ends.
// Assumes DATA_W is at least 32 and configuration is static within a frame.
module srx_framer #(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 7,
    parameter int BLK_SIZE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp,
    input  logic              fs_start,
    input  logic              ser_dat,
    input  logic              dual_phase,
    input  logic [2:0]        p1_len,
    input  logic [CNT_W-1:0]  p1_cnt,
    input  logic [2:0]        p2_len,
    input  logic [CNT_W-1:0]  p2_cnt,
    output logic              word_v,
    output logic [DATA_W-1:0] word,
    output logic              start_q,
    output logic              err_q,
    output logic              blk_q,
    output logic              active
);
    import srx_pkg::*;
    localparam int BCNT_W   = $clog2(DATA_W) + 1;
    localparam int CH_W     = CNT_W + 1;
    localparam int BLK_BITS = $clog2(BLK_SIZE);

    logic              phase;
    logic [BCNT_W-1:0] bcnt;
    logic [CNT_W-1:0]  wcnt;
    logic [CH_W-1:0]   chan;
    logic [DATA_W-1:0] shift;
    logic [DATA_W-1:0] shift_nx;
    logic [BCNT_W-1:0] last_bit;
    logic [CNT_W-1:0]  cnt_cur;

    // Selects the field set of the current phase.
    always_comb begin
        last_bit = BCNT_W'(code_to_len(phase ? p2_len : p1_len)) - BCNT_W'(1);
        cnt_cur  = phase ? p2_cnt : p1_cnt;
        shift_nx = {shift[DATA_W-2:0], ser_dat};
    end

    // Advances bit, word, phase and channel counters on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= 1'b0;
            bcnt    <= '0;
            wcnt    <= '0;
            chan    <= '0;
            shift   <= '0;
            word    <= '0;
            word_v  <= 1'b0;
            start_q <= 1'b0;
            err_q   <= 1'b0;
            blk_q   <= 1'b0;
            active  <= 1'b0;
        end else begin
            word_v  <= 1'b0;
            start_q <= 1'b0;
            err_q   <= 1'b0;
            blk_q   <= 1'b0;
            if (smp && fs_start) begin
                start_q <= 1'b1;
                err_q   <= active;
                active  <= 1'b1;
                phase   <= 1'b0;
                wcnt    <= '0;
                chan    <= '0;
                shift   <= {{(DATA_W-1){1'b0}}, ser_dat};
                bcnt    <= BCNT_W'(1);
            end else if (smp && active) begin
                if (bcnt == last_bit) begin
                    word_v <= 1'b1;
                    word   <= shift_nx;
                    shift  <= '0;
                    bcnt   <= '0;
                    chan   <= chan + CH_W'(1);
                    blk_q  <= (chan[BLK_BITS-1:0] == {BLK_BITS{1'b1}});
                    if (wcnt == cnt_cur) begin
                        wcnt <= '0;
                        if (!phase && dual_phase) phase  <= 1'b1;
                        else                      active <= 1'b0;
                    end else begin
                        wcnt <= wcnt + CNT_W'(1);
                    end
                end else begin
                    shift <= shift_nx;
                    bcnt  <= bcnt + BCNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/srx_buffer.sv
// Buffer register and host data register with ready and overrun flags.
// Assumes finished words arrive at least two cycles apart.
module srx_buffer #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_v,
    input  logic [DATA_W-1:0] word,
    input  logic              rd,
    output logic [DATA_W-1:0] data,
    output logic              rdy,
    output logic              ovr,
    output logic              ld_q,
    output logic              buf_v
);
    logic [DATA_W-1:0] buf_q;

    // Moves buffered words on, or drops them as overrun, and serves reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            buf_v <= 1'b0;
            data  <= '0;
            rdy   <= 1'b0;
            ovr   <= 1'b0;
            ld_q  <= 1'b0;
        end else begin
            ld_q <= 1'b0;
            if (word_v) begin
                buf_q <= word;
                buf_v <= 1'b1;
            end else begin
                buf_v <= 1'b0;
            end
            if (buf_v) begin
                if (!rdy || rd) begin
                    data <= buf_q;
                    rdy  <= 1'b1;
                    ld_q <= 1'b1;
                    if (rd) ovr <= 1'b0;
                end else begin
                    ovr <= 1'b1;
                end
            end else if (rd) begin
                rdy <= 1'b0;
                ovr <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/srx_top.sv
// Dual-phase framed serial receiver: edge detect, framer, buffer and
// interrupt source select. Configuration must be static during a frame.
module srx_top #(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 7,
    parameter int BLK_SIZE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_fs,
    input  logic              ser_dat,
    input  logic              clk_pol,
    input  logic              fs_pol,
    input  logic              dual_phase,
    input  logic [2:0]        p1_len,
    input  logic [CNT_W-1:0]  p1_cnt,
    input  logic [2:0]        p2_len,
    input  logic [CNT_W-1:0]  p2_cnt,
    input  logic [1:0]        irq_mode,
    input  logic              rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rdy,
    output logic              ovr,
    output logic              irq
);
    import srx_pkg::*;

    logic              smp, fs_start;
    logic              word_v, start_q, err_q, blk_q, active;
    logic [DATA_W-1:0] word;
    logic              ld_q, buf_v;

    srx_edge u_edge (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_fs(ser_fs),
        .clk_pol(clk_pol), .fs_pol(fs_pol), .smp(smp), .fs_start(fs_start)
    );

    srx_framer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .BLK_SIZE(BLK_SIZE)) u_frm (
        .clk(clk), .rst_n(rst_n), .smp(smp), .fs_start(fs_start),
        .ser_dat(ser_dat), .dual_phase(dual_phase),
        .p1_len(p1_len), .p1_cnt(p1_cnt), .p2_len(p2_len), .p2_cnt(p2_cnt),
        .word_v(word_v), .word(word), .start_q(start_q), .err_q(err_q),
        .blk_q(blk_q), .active(active)
    );

    srx_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .word_v(word_v), .word(word), .rd(rd),
        .data(rx_data), .rdy(rdy), .ovr(ovr), .ld_q(ld_q), .buf_v(buf_v)
    );

    // Routes the selected event pulse to the interrupt output.
    always_comb begin
        case (irq_sel_e'(irq_mode))
            IRQ_LOAD:   irq = ld_q;
            IRQ_BLOCK:  irq = blk_q;
            IRQ_FRAME:  irq = start_q;
            default:    irq = err_q;
        endcase
    end
endmodule

// File: rtl/srx_chk.sv
// Protocol checks for srx_top, attached with bind.
module srx_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd,
    input logic              rdy,
    input logic              ovr,
    input logic [DATA_W-1:0] rx_data,
    input logic              err_q,
    input logic              start_q,
    input logic              word_v,
    input logic              active
);
    // R6
    rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(rd));
    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> rdy);
    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !rd) |=> $stable(rx_data));
    // R9
    err_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> start_q);
    // R8
    word_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_v |-> $past(active));
endmodule

bind srx_top srx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd(rd), .rdy(rdy), .ovr(ovr),
    .rx_data(rx_data), .err_q(u_frm.err_q), .start_q(u_frm.start_q),
    .word_v(u_frm.word_v), .active(u_frm.active)
);

// File: tb/sim_srx_top.sv
// Scoreboard bench: driver tasks queue expected words, a monitor pops them.
module sim_srx_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_fs = 1'b0, ser_dat = 1'b0;
    logic        clk_pol = 1'b1, fs_pol = 1'b1, dual_phase = 1'b0;
    logic [2:0]  p1_len = 3'd0, p2_len = 3'd0;
    logic [6:0]  p1_cnt = 7'd0, p2_cnt = 7'd0;
    logic [1:0]  irq_mode = 2'b00;
    logic        rd = 1'b0;
    logic [31:0] rx_data;
    logic        rdy, ovr, irq;

    int          n_cmp = 0, n_bad = 0, irq_cnt = 0;
    bit          auto_rd = 1'b0;
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    srx_top u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_fs(ser_fs),
        .ser_dat(ser_dat), .clk_pol(clk_pol), .fs_pol(fs_pol),
        .dual_phase(dual_phase), .p1_len(p1_len), .p1_cnt(p1_cnt),
        .p2_len(p2_len), .p2_cnt(p2_cnt), .irq_mode(irq_mode), .rd(rd),
        .rx_data(rx_data), .rdy(rdy), .ovr(ovr), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic fs);
        ser_clk = clk_pol ? 1'b0 : 1'b1;
        ser_dat = b;
        ser_fs  = fs_pol ? fs : ~fs;
        repeat (4) @(negedge clk);
        ser_clk = ~ser_clk;
        repeat (4) @(negedge clk);
    endtask

    task automatic idle_bits(input int n, input logic b);
        for (int i = 0; i < n; i++) send_bit(b, 1'b0);
    endtask

    task automatic send_word(input logic [31:0] val, input int len, input logic first);
        logic [31:0] m;
        m = (len >= 32) ? val : (val & ((32'd1 << len) - 32'd1));
        exp_q.push_back(m);
        for (int i = len - 1; i >= 0; i--) send_bit(val[i], first && (i == len - 1));
    endtask

    task automatic drain(input string req);
        repeat (20) @(negedge clk);
        chk(req, 32'(exp_q.size()), 32'd0);
    endtask

    // Monitor: pops one expected word per ready and reads it out.
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rd) begin
                rd = 1'b0;
                if (rdy) begin
                    if (exp_q.size() == 0) begin
                        n_cmp++; n_bad++;
                        $display("FAIL R8: actual %h expected no word", rx_data);
                    end else begin
                        chk("R2/R3/R5 word", rx_data, exp_q.pop_front());
                    end
                    rd = 1'b1;
                end
            end
        end
    end

    // Counts one-cycle interrupt pulses.
    initial forever begin
        @(negedge clk);
        if (irq) irq_cnt++;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        chk("R14 rdy", 32'(rdy), 0);
        chk("R14 ovr", 32'(ovr), 0);
        chk("R14 irq", 32'(irq), 0);
        chk("R14 rx_data", rx_data, 0);
        auto_rd = 1'b1;

        // R1 R4 R10: single phase, 8-bit, three words, load interrupts
        irq_mode = 2'b00; p1_len = 3'd0; p1_cnt = 7'd2; irq_cnt = 0;
        idle_bits(1, 1'b0);
        send_word(32'hA5, 8, 1'b1); send_word(32'h3C, 8, 1'b0); send_word(32'hFF, 8, 1'b0);
        drain("R4 three words delivered");
        chk("R10 load irq count", 32'(irq_cnt), 3);

        // R5 R12: dual phase 8-bit x1 then 16-bit x2, frame interrupt
        irq_mode = 2'b10; dual_phase = 1'b1; p1_len = 3'd0; p1_cnt = 7'd0;
        p2_len = 3'd2; p2_cnt = 7'd1; irq_cnt = 0;
        idle_bits(1, 1'b0);
        send_word(32'h9C, 8, 1'b1); send_word(32'hBEEF, 16, 1'b0); send_word(32'h1234, 16, 1'b0);
        drain("R5 dual phase words delivered");
        chk("R12 frame irq count", 32'(irq_cnt), 1);
        dual_phase = 1'b0;

        // R3: every length code, single-word frames
        p1_cnt = 7'd0;
        p1_len = 3'd1; idle_bits(1, 1'b0); send_word(32'hABC, 12, 1'b1);
        p1_len = 3'd3; idle_bits(1, 1'b0); send_word(32'h5A5A5, 20, 1'b1);
        p1_len = 3'd4; idle_bits(1, 1'b0); send_word(32'hC0FFEE, 24, 1'b1);
        p1_len = 3'd5; idle_bits(1, 1'b0); send_word(32'hDEADBEEF, 32, 1'b1);
        p1_len = 3'd6; idle_bits(1, 1'b0); send_word(32'h80000001, 32, 1'b1);
        p1_len = 3'd7; idle_bits(1, 1'b0); send_word(32'h7FFFFFFE, 32, 1'b1);
        drain("R3 length codes delivered");

        // R1 R2: falling edge sampling, active-low sync
        clk_pol = 1'b0; fs_pol = 1'b0; p1_len = 3'd2; p1_cnt = 7'd1;
        idle_bits(2, 1'b0);
        send_word(32'h8001, 16, 1'b1); send_word(32'h7FFE, 16, 1'b0);
        drain("R1 falling edge words delivered");
        clk_pol = 1'b1; fs_pol = 1'b1;

        // R8: bits after a finished frame are ignored
        irq_mode = 2'b00; p1_len = 3'd0; p1_cnt = 7'd0; irq_cnt = 0;
        idle_bits(2, 1'b0);
        send_word(32'h5C, 8, 1'b1);
        idle_bits(12, 1'b1);
        drain("R8 no extra word");
        chk("R8 load irq count", 32'(irq_cnt), 1);
        chk("R8 rdy idle", 32'(rdy), 0);

        // R9 R13: sync restart in mid word
        irq_mode = 2'b11; p1_len = 3'd0; p1_cnt = 7'd1; irq_cnt = 0;
        idle_bits(1, 1'b0);
        send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
        send_word(32'h5A, 8, 1'b1); send_word(32'hC3, 8, 1'b0);
        drain("R9 restarted frame delivered");
        chk("R13 sync error irq count", 32'(irq_cnt), 1);

        // R11: 17-word frame gives one block event
        irq_mode = 2'b01; p1_cnt = 7'd16; irq_cnt = 0;
        idle_bits(1, 1'b0);
        for (int i = 0; i < 17; i++) send_word(32'(i * 7 + 3), 8, i == 0);
        drain("R11 block words delivered");
        chk("R11 block irq count", 32'(irq_cnt), 1);

        // R7 R6: overrun without reads
        auto_rd = 1'b0; rd = 1'b0; irq_mode = 2'b00; p1_cnt = 7'd1;
        idle_bits(1, 1'b0);
        send_word(32'h11, 8, 1'b1); send_word(32'h22, 8, 1'b0);
        repeat (10) @(negedge clk);
        exp_q.delete();
        chk("R7 data kept", rx_data, 32'h11);
        chk("R7 ovr set", 32'(ovr), 1);
        chk("R6 rdy held", 32'(rdy), 1);
        rd = 1'b1; @(negedge clk); rd = 1'b0;
        chk("R6 rdy cleared by read", 32'(rdy), 0);
        chk("R7 ovr cleared by read", 32'(ovr), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule